// File: doc/BRIEF.md
# Multiplexed Key Matrix Scanner

This block scans a 16 by 16 key matrix through a narrow pin set. It sends out a 4-bit strobe number that outside logic decodes into one of 16 strobe lines. The 16 return lines come back through outside multiplexers four at a time. A 2-bit group select picks which four sit on the 4-bit return bus. Two more return inputs are wired straight to the scanner: one carries a mode switch, the other carries the clerk, paper-feed and receipt switches. All of these switches sit on the same strobe lines as the keys.

Each strobe step is split into four equal sub-phases, one for each return group. The sub-phase length is `SUB_CYC` clocks; the default matches about 10 us at 200 MHz, which gives a strobe step of about 40 us. The scanner samples the bus on the last clock of each sub-phase, so the outside logic has the rest of the sub-phase to settle. At the end of each strobe step the block presents an 18-bit return word for that strobe. It keeps a complete map of the matrix. A change in that map is reported only once two scans in a row agree.

Top module: `kmx_scanner`

## Requirements
- R1: While `rst_n` is low, `strobe_code`, `grp_sel`, `row_valid` and `ev_valid` are 0, and no key is held as closed.
- R2: `grp_sel` holds each value for `SUB_CYC` clocks and runs 0, 1, 2, 3, then starts again at 0.
- R3: `strobe_code` goes up by one after every four group sub-phases (4*`SUB_CYC` clocks). After 15 it returns to 0.
- R4: `ret_in` is sampled on the last clock of each sub-phase. Bit i sampled with group g becomes bit 4*g+i of `row_word`. A return line that is high means the key is closed.
- R5: `mode_ret` and `aux_ret` are sampled on the last clock of the group-3 sub-phase and appear as `row_mode` and `row_aux`.
- R6: `row_valid` is high for exactly one clock. That clock comes right after the last sample of a strobe step, and `row_strobe` then holds the strobe number of that step.
- R7: A change is reported only when the two most recent scans of a strobe give the same value for a return and that value differs from the state already reported. A change seen in only one scan is never reported.
- R8: A report holds `ev_valid` high for one clock. `ev_strobe` gives the strobe. `ev_ret` gives the return index: 0 to 15 for the main returns, 16 for the mode switch, 17 for the aux switch. `ev_press` gives the new state, 1 for closed and 0 for open.
- R9: All changes found for one strobe are reported on consecutive clocks in ascending `ev_ret` order. The first report comes on the clock after `row_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_code | output | 4 | Encoded strobe number, decoded outside the block |
| grp_sel | output | 2 | Select for the outside return multiplexers |
| ret_in | input | 4 | Return group currently selected, high = closed |
| mode_ret | input | 1 | Dedicated return line for the mode switch |
| aux_ret | input | 1 | Dedicated return line for the clerk, feed and receipt switches |
| row_valid | output | 1 | One-clock pulse marking a finished strobe step |
| row_strobe | output | 4 | Strobe number of that step |
| row_word | output | 16 | Main returns sampled in that step |
| row_mode | output | 1 | Mode switch sample of that step |
| row_aux | output | 1 | Aux switch sample of that step |
| ev_valid | output | 1 | Debounced change report |
| ev_strobe | output | 4 | Strobe of the reported change |
| ev_ret | output | 5 | Return index of the reported change |
| ev_press | output | 1 | New state: 1 closed, 0 open |

## Verification
The strobe and group outputs are registered, so they follow the clock count after reset with no delay. Bus values sampled on the last clock of a sub-phase show up in the row outputs on the first clock of the next strobe step. The first debounced report comes one clock after that, and each further report follows on the next clock. The bench model counts clocks since reset to place each sample. It queues row and report expectations for exactly those clocks and compares every output on the falling edge of every clock. A missing, extra or early report therefore fails on the clock where it occurs. Short key pulses are lined up with one strobe step, so that exactly one scan sees them.

// File: rtl/kmx_pkg.sv
package kmx_pkg;
  // matrix geometry
  localparam int unsigned STB_N   = 16;
  localparam int unsigned STB_W   = $clog2(STB_N);
  localparam int unsigned GRP_N   = 4;
  localparam int unsigned GRP_W   = 4;
  localparam int unsigned SEL_W   = $clog2(GRP_N);
  localparam int unsigned MAIN_N  = GRP_N * GRP_W;
  localparam int unsigned EXTRA_N = 2;
  localparam int unsigned ROW_W   = MAIN_N + EXTRA_N;
  localparam int unsigned IDX_W   = $clog2(ROW_W);
  localparam int unsigned IDX_MODE = MAIN_N;
  localparam int unsigned IDX_AUX  = MAIN_N + 1;

  typedef logic [ROW_W-1:0] row_t;
  typedef logic [STB_W-1:0] stb_t;
  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [GRP_W-1:0] grp_t;
endpackage

// File: rtl/kmx_timing.sv
module kmx_timing
  import kmx_pkg::*;
#(
  parameter int unsigned SUB_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  output stb_t stb_o,
  output sel_t sel_o,
  output logic smp_o,
  output logic step_end_o
);
  localparam int unsigned CNT_W = (SUB_CYC > 1) ? $clog2(SUB_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUB_CYC - 1);
  localparam sel_t SEL_LAST = SEL_W'(GRP_N - 1);
  localparam stb_t STB_LAST = STB_W'(STB_N - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  sel_t sel_q, sel_d;
  stb_t stb_q, stb_d;
  logic sub_last, grp_last;

  always_comb begin
    sub_last = (cnt_q == CNT_LAST);
    grp_last = (sel_q == SEL_LAST);
    cnt_d    = sub_last ? '0 : cnt_q + 1'b1;
    sel_d    = sel_q;
    stb_d    = stb_q;
    if (sub_last) begin
      sel_d = grp_last ? '0 : sel_q + 1'b1;
      if (grp_last) begin
        stb_d = (stb_q == STB_LAST) ? '0 : stb_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
      stb_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
      stb_q <= stb_d;
    end
  end

  assign stb_o      = stb_q;
  assign sel_o      = sel_q;
  assign smp_o      = sub_last;
  assign step_end_o = sub_last && grp_last;
endmodule

// File: rtl/kmx_capture.sv
module kmx_capture
  import kmx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic step_end_i,
  input  sel_t sel_i,
  input  stb_t stb_i,
  input  grp_t ret_i,
  input  logic mode_i,
  input  logic aux_i,
  output logic row_valid_o,
  output stb_t row_stb_o,
  output row_t row_o
);
  grp_t acc_q [GRP_N-1];
  row_t word_w;

  // groups 0..GRP_N-2 are held; the last group is taken straight from the bus
  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    if (g < GRP_N - 1) begin : g_held
      logic acc_en;
      assign acc_en = smp_i && (sel_i == SEL_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q[g] <= '0;
        end else if (acc_en) begin
          acc_q[g] <= ret_i;
        end
      end
      assign word_w[g*GRP_W +: GRP_W] = acc_q[g];
    end else begin : g_live
      assign word_w[g*GRP_W +: GRP_W] = ret_i;
    end
  end
  assign word_w[IDX_MODE] = mode_i;
  assign word_w[IDX_AUX]  = aux_i;

  logic row_valid_q, row_valid_d;
  stb_t row_stb_q, row_stb_d;
  row_t row_q, row_d;

  always_comb begin
    row_valid_d = step_end_i;
    row_stb_d   = step_end_i ? stb_i  : row_stb_q;
    row_d       = step_end_i ? word_w : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_valid_q <= 1'b0;
      row_stb_q   <= '0;
      row_q       <= '0;
    end else begin
      row_valid_q <= row_valid_d;
      row_stb_q   <= row_stb_d;
      row_q       <= row_d;
    end
  end

  assign row_valid_o = row_valid_q;
  assign row_stb_o   = row_stb_q;
  assign row_o       = row_q;
endmodule

// File: rtl/kmx_debounce.sv
module kmx_debounce
  import kmx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic row_valid_i,
  input  stb_t row_stb_i,
  input  row_t row_i,
  output logic ev_valid_o,
  output stb_t ev_stb_o,
  output idx_t ev_idx_o,
  output logic ev_press_o
);
  row_t prev_q [STB_N];
  row_t stab_q [STB_N];
  row_t pend_q, pend_d;
  stb_t pend_stb_q, pend_stb_d;

  row_t fresh, work_mask, lo_hot, work_stab;
  stb_t work_stb;
  idx_t lo_idx;
  logic found;

  logic ev_valid_q, ev_valid_d;
  stb_t ev_stb_q, ev_stb_d;
  idx_t ev_idx_q, ev_idx_d;
  logic ev_press_q, ev_press_d;

  always_comb begin
    // agreed by two scans and different from the reported state
    fresh     = ~(row_i ^ prev_q[row_stb_i]) & (row_i ^ stab_q[row_stb_i]);
    work_mask = row_valid_i ? fresh : pend_q;
    work_stb  = row_valid_i ? row_stb_i : pend_stb_q;
    lo_idx    = '0;
    for (int i = ROW_W - 1; i >= 0; i--) begin
      if (work_mask[i]) lo_idx = IDX_W'(i);
    end
    found     = |work_mask;
    lo_hot    = found ? (row_t'(1) << lo_idx) : '0;
    work_stab = stab_q[work_stb];
    pend_d     = work_mask & ~lo_hot;
    pend_stb_d = work_stb;
    ev_valid_d = found;
    ev_stb_d   = found ? work_stb : ev_stb_q;
    ev_idx_d   = found ? lo_idx   : ev_idx_q;
    ev_press_d = found ? ~work_stab[lo_idx] : ev_press_q;
  end

  for (genvar s = 0; s < STB_N; s++) begin : g_map
    logic prev_we, stab_we;
    assign prev_we = row_valid_i && (row_stb_i == STB_W'(s));
    assign stab_we = found && (work_stb == STB_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[s] <= '0;
        stab_q[s] <= '0;
      end else begin
        if (prev_we) prev_q[s] <= row_i;
        if (stab_we) stab_q[s] <= stab_q[s] ^ lo_hot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_stb_q <= '0;
      ev_valid_q <= 1'b0;
      ev_stb_q   <= '0;
      ev_idx_q   <= '0;
      ev_press_q <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      pend_stb_q <= pend_stb_d;
      ev_valid_q <= ev_valid_d;
      ev_stb_q   <= ev_stb_d;
      ev_idx_q   <= ev_idx_d;
      ev_press_q <= ev_press_d;
    end
  end

  assign ev_valid_o = ev_valid_q;
  assign ev_stb_o   = ev_stb_q;
  assign ev_idx_o   = ev_idx_q;
  assign ev_press_o = ev_press_q;
endmodule

// File: rtl/kmx_scanner.sv
module kmx_scanner
  import kmx_pkg::*;
#(
  parameter int unsigned SUB_CYC = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [3:0]  strobe_code,
  output logic [1:0]  grp_sel,
  input  logic [3:0]  ret_in,
  input  logic        mode_ret,
  input  logic        aux_ret,
  output logic        row_valid,
  output logic [3:0]  row_strobe,
  output logic [15:0] row_word,
  output logic        row_mode,
  output logic        row_aux,
  output logic        ev_valid,
  output logic [3:0]  ev_strobe,
  output logic [4:0]  ev_ret,
  output logic        ev_press
);
  stb_t stb_w;
  sel_t sel_w;
  logic smp_w, step_end_w;
  logic rv_w;
  stb_t rs_w;
  row_t row_w;

  kmx_timing #(.SUB_CYC(SUB_CYC)) u_timing (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb_o      (stb_w),
    .sel_o      (sel_w),
    .smp_o      (smp_w),
    .step_end_o (step_end_w)
  );

  kmx_capture u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_i       (smp_w),
    .step_end_i  (step_end_w),
    .sel_i       (sel_w),
    .stb_i       (stb_w),
    .ret_i       (ret_in),
    .mode_i      (mode_ret),
    .aux_i       (aux_ret),
    .row_valid_o (rv_w),
    .row_stb_o   (rs_w),
    .row_o       (row_w)
  );

  kmx_debounce u_debounce (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_valid_i (rv_w),
    .row_stb_i   (rs_w),
    .row_i       (row_w),
    .ev_valid_o  (ev_valid),
    .ev_stb_o    (ev_strobe),
    .ev_idx_o    (ev_ret),
    .ev_press_o  (ev_press)
  );

  assign strobe_code = stb_w;
  assign grp_sel     = sel_w;
  assign row_valid   = rv_w;
  assign row_strobe  = rs_w;
  assign row_word    = row_w[MAIN_N-1:0];
  assign row_mode    = row_w[IDX_MODE];
  assign row_aux     = row_w[IDX_AUX];
endmodule

// File: rtl/kmx_scanner_chk.sv
module kmx_scanner_chk
  import kmx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  strobe_code,
  input logic [1:0]  grp_sel,
  input logic        row_valid,
  input logic [3:0]  row_strobe,
  input logic        ev_valid,
  input logic [3:0]  ev_strobe,
  input logic [4:0]  ev_ret
);
  // R1: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (strobe_code == 4'd0 && grp_sel == 2'd0 && !row_valid && !ev_valid)
        else $error("reset state violated");
    end
  end

  // R2: group select only steps forward by one
  p_grp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_sel != $past(grp_sel)) |-> (grp_sel == 2'($past(grp_sel) + 2'd1)));

  // R3: strobe advances only on a group wrap
  p_strobe_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_code != $past(strobe_code)) |->
      ($past(grp_sel) == 2'd3 && grp_sel == 2'd0 && strobe_code == 4'($past(strobe_code) + 4'd1)));

  // R6: one-clock row pulse following the last group
  p_row_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |=> !row_valid);

  p_row_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_valid |-> ($past(grp_sel) == 2'd3 && grp_sel == 2'd0 && row_strobe == $past(strobe_code)));

  // R8: return index within the defined range
  p_ev_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_ret <= 5'(IDX_AUX)));

  // R9: a burst of reports starts right after a row
  p_ev_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_valid) |-> $past(row_valid));

  // R9: back-to-back reports ascend within one strobe
  p_ev_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && $past(ev_valid)) |-> (ev_ret > $past(ev_ret) && ev_strobe == $past(ev_strobe)));
endmodule

bind kmx_scanner kmx_scanner_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strobe_code (strobe_code),
  .grp_sel     (grp_sel),
  .row_valid   (row_valid),
  .row_strobe  (row_strobe),
  .ev_valid    (ev_valid),
  .ev_strobe   (ev_strobe),
  .ev_ret      (ev_ret)
);

// File: tb/kmx_scanner_test.sv
`timescale 1ns/1ps
module kmx_scanner_test;
  localparam int SUB  = 5;
  localparam int STEP = 4 * SUB;
  localparam int SCAN = 16 * STEP;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [3:0]  strobe_code;
  logic [1:0]  grp_sel;
  logic [3:0]  ret_in;
  logic        mode_ret, aux_ret;
  logic        row_valid, row_mode, row_aux;
  logic [3:0]  row_strobe;
  logic [15:0] row_word;
  logic        ev_valid, ev_press;
  logic [3:0]  ev_strobe;
  logic [4:0]  ev_ret;

  // outside matrix: bit r of keys[s] closes return r on strobe s (16 = mode, 17 = aux)
  logic [17:0] keys [16];
  assign ret_in   = keys[strobe_code][{grp_sel, 2'b00} +: 4];
  assign mode_ret = keys[strobe_code][16];
  assign aux_ret  = keys[strobe_code][17];

  kmx_scanner #(.SUB_CYC(SUB)) uut (
    .clk(clk), .rst_n(rst_n), .strobe_code(strobe_code), .grp_sel(grp_sel),
    .ret_in(ret_in), .mode_ret(mode_ret), .aux_ret(aux_ret),
    .row_valid(row_valid), .row_strobe(row_strobe), .row_word(row_word),
    .row_mode(row_mode), .row_aux(row_aux), .ev_valid(ev_valid),
    .ev_strobe(ev_strobe), .ev_ret(ev_ret), .ev_press(ev_press)
  );

  int checks = 0;
  int errors = 0;
  bit active = 0;
  bit done = 0;
  int n;

  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  typedef struct { int s; int r; int p; } ev_t;
  ev_t evq[$];
  logic [17:0] m_prev [16];
  logic [17:0] m_stab [16];
  logic [17:0] m_acc;
  bit          row_due = 0;
  int          row_s;
  logic [17:0] row_w;

  always @(negedge clk) begin
    if (active && !done) begin
      int e_grp, e_stb, e_sub;
      bit rv_exp;
      e_sub = n % SUB;
      e_grp = (n / SUB) % 4;
      e_stb = (n / STEP) % 16;
      chk(strobe_code == 4'(e_stb), "R3 strobe_code", strobe_code, e_stb);
      chk(grp_sel == 2'(e_grp), "R2 grp_sel", grp_sel, e_grp);

      rv_exp = row_due;
      row_due = 0;
      chk(row_valid == rv_exp, "R6 row_valid", row_valid, rv_exp);
      if (rv_exp) begin
        chk(row_strobe == 4'(row_s), "R6 row_strobe", row_strobe, row_s);
        chk(row_word == row_w[15:0], "R4 row_word", row_word, row_w[15:0]);
        chk(row_mode == row_w[16], "R5 row_mode", row_mode, row_w[16]);
        chk(row_aux == row_w[17], "R5 row_aux", row_aux, row_w[17]);
      end

      if (evq.size() > 0) begin
        ev_t e;
        e = evq.pop_front();
        chk(ev_valid == 1'b1, "R7 ev_valid expected", ev_valid, 1);
        chk(ev_strobe == 4'(e.s), "R8 ev_strobe", ev_strobe, e.s);
        chk(ev_ret == 5'(e.r), "R8 R9 ev_ret", ev_ret, e.r);
        chk(ev_press == e.p[0], "R8 ev_press", ev_press, e.p);
      end else begin
        chk(ev_valid == 1'b0, "R7 ev_valid unexpected", ev_valid, 0);
      end

      if (rv_exp) begin
        for (int r = 0; r < 18; r++) begin
          if (row_w[r] == m_prev[row_s][r] && row_w[r] != m_stab[row_s][r]) begin
            evq.push_back('{s: row_s, r: r, p: int'(row_w[r])});
            m_stab[row_s][r] = row_w[r];
          end
        end
        m_prev[row_s] = row_w;
      end

      if (e_sub == SUB - 1) begin
        m_acc[e_grp*4 +: 4] = keys[e_stb][e_grp*4 +: 4];
        if (e_grp == 3) begin
          m_acc[16] = keys[e_stb][16];
          m_acc[17] = keys[e_stb][17];
          row_due = 1;
          row_s   = e_stb;
          row_w   = m_acc;
        end
      end
    end
  end

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wait_phase(input int ph);
    do begin
      @(posedge clk);
      #1;
    end while ((n % SCAN) != ph);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int s = 0; s < 16; s++) begin
      keys[s]   = '0;
      m_prev[s] = '0;
      m_stab[s] = '0;
    end
    m_acc = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(strobe_code == 4'd0, "R1 strobe_code in reset", strobe_code, 0);
    chk(grp_sel == 2'd0, "R1 grp_sel in reset", grp_sel, 0);
    chk(row_valid == 1'b0, "R1 row_valid in reset", row_valid, 0);
    chk(ev_valid == 1'b0, "R1 ev_valid in reset", ev_valid, 0);
    rst_n  = 1'b1;
    active = 1;

    // idle scans: no reports (R7)
    wait_cyc(2 * SCAN);
    // single key press and release (R7, R8)
    keys[3][5] = 1'b1;
    wait_cyc(2 * SCAN + 50);
    keys[3][5] = 1'b0;
    wait_cyc(2 * SCAN + 50);
    // glitch on strobe 9 seen by exactly one scan (R7)
    wait_phase(9 * STEP);
    keys[9][2] = 1'b1;
    wait_cyc(STEP - 2);
    keys[9][2] = 1'b0;
    wait_cyc(2 * SCAN + 50);
    // several changes on one strobe, incl. mode and aux (R5, R9)
    keys[12] = 18'h3_0021;
    wait_cyc(2 * SCAN + 50);
    keys[12] = 18'h1_0001;
    wait_cyc(2 * SCAN + 50);
    // full rows on the first and last strobe (R4, R9)
    keys[15] = 18'h0_FFFF;
    keys[0]  = 18'h3_A5C3;
    wait_cyc(2 * SCAN + 50);
    for (int s = 0; s < 16; s++) keys[s] = '0;
    wait_cyc(2 * SCAN + 50);
    finish_run();
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
      finish_run();
    end
  end
endmodule